// File: doc/BRIEF.md
# Raster 4:2:2 Strip to MCU Block Reorderer

This block sits at the front of a baseline still-image compression pipeline. It takes packed 4:2:2 video in raster order on an AXI4-Stream slave, one 16-bit word per pixel, and splits each word into a luma sample and a chroma sample. Chroma alternates between Cb and Cr from one pixel to the next. Each plane is written into its own line memory, and the memories hold two strips of eight lines each.

While one strip fills, the other strip is read out as a stream of 8x8 sample blocks. The blocks come out in the order that a 4:2:2 MCU of 16x8 pixels needs: the left luma block, the right luma block, then Cb, then Cr. A strip is read out only after all eight of its lines have arrived. The input is stalled through tready only when both strips are waiting to be read out. Each output sample carries a 2-bit block tag, a block-start marker and a frame-start marker, so a downstream transform can frame its work without counting.

Image width and height are synthesis parameters. The width is a multiple of 16 and the height a multiple of 8. The output has no backpressure and delivers one sample per cycle for every block in a strip.

Top module: `yuyv_mcu_reorder`

## Requirements
- R1: Each accepted input word is split so that bits [7:0] are the luma sample of that pixel and bits [15:8] are a chroma sample. That chroma sample is Cb when the pixel column is even and Cr when it is odd, and it belongs to the pixel pair at column/2.
- R2: Within each MCU, four blocks of 64 samples are emitted one sample per cycle with no gap, each in row-major order. Tag 0 is luma columns 16m..16m+7, tag 1 is luma columns 16m+8..16m+15, tag 2 is Cb pairs 8m..8m+7 and tag 3 is Cr pairs 8m..8m+7, where m is the MCU index.
- R3: MCUs of a strip are emitted left to right and strips top to bottom. No sample of a strip is emitted before all eight of its lines have been accepted.
- R4: m_block_start is high exactly on the first sample of each block. m_frame_start is high exactly on the first sample of the first block of the first strip of a frame.
- R5: s_tready is low only while both strips hold complete, not yet read lines. Idle cycles on s_tvalid and stalls have no effect on where samples are placed.
- R6: A beat with s_tuser high is placed as pixel column 0, line 0 of a new frame, whatever position the input had reached.
- R7: A beat with s_tlast high ends its line. If its column is not the last one (width-1), the line still counts as complete and line_err is set and stays set until reset. A tlast on the last column leaves line_err low.
- R8: The smallest frame, 16x8 pixels (one MCU), is reordered correctly, and successive frames alternate between the two strips.
- R9: After reset, s_tready is high, m_valid is low and line_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 16 | Packed pixel: [15:8] chroma, [7:0] luma |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Input word accepted when high with s_tvalid |
| s_tlast | input | 1 | Last pixel of a line |
| s_tuser | input | 1 | First pixel of a frame |
| m_sample | output | 8 | Output block sample |
| m_valid | output | 1 | Output sample valid |
| m_tag | output | 2 | Block tag: 0 left luma, 1 right luma, 2 Cb, 3 Cr |
| m_block_start | output | 1 | First sample of a block |
| m_frame_start | output | 1 | First sample of a frame |
| line_err | output | 1 | Sticky flag for a line ended early |

## Verification
The bench builds two copies of the block. One is 32x16, which gives two MCUs per strip and two strips per frame, so MCU ordering, strip ping-pong and stall under backpressure all occur. The other is the 16x8 single-MCU frame, where the column and strip counters wrap on every MCU. Every output sample of every frame is compared with a value computed arithmetically from its pixel coordinates and frame number, while random idle gaps are placed on the input. The wide copy also receives partial-line junk before a tuser resync. The small copy ends with a frame of short lines, which exercises the sticky error flag and early line completion.

// File: rtl/mcu_reorder_pkg.sv
// Shared types for the strip-to-MCU reorderer.
// Assumes a 4:2:2 MCU of two luma blocks followed by Cb and Cr.
package mcu_reorder_pkg;

    // Block tag carried with each output sample; the value is also the
    // position of the block inside its MCU.
    typedef enum logic [1:0] {
        TAG_Y_LEFT  = 2'd0,
        TAG_Y_RIGHT = 2'd1,
        TAG_CB      = 2'd2,
        TAG_CR      = 2'd3
    } blk_tag_e;

    localparam int BLK_DIM   = 8;
    localparam int MCU_WIDTH = 16;

endpackage

// File: rtl/lane_ram.sv
// Simple dual-port sample memory: one synchronous write port and one
// registered read port. Assumes no read-during-write to the same address
// (the strip ping-pong guarantees it). Content has no reset.
module lane_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/strip_writer.sv
// Input side: accepts raster 4:2:2 words, tracks column, line and strip
// position, splits luma and chroma into plane write ports, and owns the
// two strip-full flags. Assumes W is a multiple of 16 and H a multiple
// of 8. tuser forces the beat to pixel (0,0); an early tlast ends the line
// and sets a sticky error.
module strip_writer #(
    parameter int W = 32,
    parameter int H = 16,
    localparam int NS  = H / 8,
    localparam int XW  = $clog2(W),
    localparam int SW  = (NS > 1) ? $clog2(NS) : 1,
    localparam int YAW = $clog2(2 * 8 * W),
    localparam int CAW = $clog2(2 * 8 * (W / 2))
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [15:0]    tdata,
    input  logic           tvalid,
    output logic           tready,
    input  logic           tlast,
    input  logic           tuser,
    input  logic [1:0]     clr_full,
    output logic [1:0]     full,
    output logic [1:0]     first_strip,
    output logic           y_we,
    output logic [YAW-1:0] y_waddr,
    output logic [7:0]     y_wdata,
    output logic           cb_we,
    output logic           cr_we,
    output logic [CAW-1:0] c_waddr,
    output logic [7:0]     c_wdata,
    output logic           line_err
);

    logic [XW-1:0] col;
    logic [2:0]    row;
    logic [SW-1:0] sidx;
    logic          wr_strip;

    logic [XW-1:0] eff_col;
    logic [2:0]    eff_row;
    logic [SW-1:0] eff_sidx;
    logic          acc;
    logic          at_last_col;
    logic          line_done;
    logic          strip_done;

    // Current position, with tuser overriding it to the frame origin.
    always_comb begin
        eff_col     = tuser ? '0 : col;
        eff_row     = tuser ? '0 : row;
        eff_sidx    = tuser ? '0 : sidx;
        tready      = ~full[wr_strip];
        acc         = tvalid & tready;
        at_last_col = (eff_col == XW'(W - 1));
        line_done   = tlast | at_last_col;
        strip_done  = acc & line_done & (eff_row == 3'd7);
    end

    // Plane write ports: luma always, chroma alternates by column parity.
    always_comb begin
        y_we    = acc;
        y_waddr = YAW'(int'(wr_strip) * 8 * W + int'(eff_row) * W + int'(eff_col));
        y_wdata = tdata[7:0];
        cb_we   = acc & ~eff_col[0];
        cr_we   = acc & eff_col[0];
        c_waddr = CAW'(int'(wr_strip) * 4 * W + int'(eff_row) * (W / 2)
                       + int'(eff_col) / 2);
        c_wdata = tdata[15:8];
    end

    // Position counters: column, line in strip, strip in frame, write strip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col      <= '0;
            row      <= '0;
            sidx     <= '0;
            wr_strip <= 1'b0;
        end else if (acc) begin
            if (line_done) begin
                col <= '0;
                if (eff_row == 3'd7) begin
                    row      <= '0;
                    wr_strip <= ~wr_strip;
                    sidx     <= (eff_sidx == SW'(NS - 1)) ? '0 : eff_sidx + 1'b1;
                end else begin
                    row  <= eff_row + 3'd1;
                    sidx <= eff_sidx;
                end
            end else begin
                col  <= eff_col + 1'b1;
                row  <= eff_row;
                sidx <= eff_sidx;
            end
        end
    end

    // Strip-full flags: set by the writer at strip end, cleared by the reader.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full        <= 2'b00;
            first_strip <= 2'b00;
        end else begin
            for (int s = 0; s < 2; s++) begin
                if (strip_done && (wr_strip == s[0])) begin
                    full[s]        <= 1'b1;
                    first_strip[s] <= (eff_sidx == '0);
                end else if (clr_full[s]) begin
                    full[s] <= 1'b0;
                end
            end
        end
    end

    // Sticky error for a line closed by tlast before the last column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_err <= 1'b0;
        end else if (acc && tlast && !at_last_col) begin
            line_err <= 1'b1;
        end
    end

endmodule

// File: rtl/mcu_reader.sv
// Output side: walks a full strip MCU by MCU, block by block, row-major
// within each block, and issues plane read addresses. Output qualifiers
// are registered one cycle to line up with the registered memory reads.
// Assumes the strip stays full until the reader releases it.
module mcu_reader
    import mcu_reorder_pkg::*;
#(
    parameter int W = 32,
    localparam int NM  = W / MCU_WIDTH,
    localparam int MW  = (NM > 1) ? $clog2(NM) : 1,
    localparam int YAW = $clog2(2 * 8 * W),
    localparam int CAW = $clog2(2 * 8 * (W / 2))
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     full,
    input  logic [1:0]     first_strip,
    output logic [1:0]     clr_full,
    output logic [YAW-1:0] y_raddr,
    output logic [CAW-1:0] c_raddr,
    output logic           o_valid,
    output blk_tag_e       o_tag,
    output logic           o_block_start,
    output logic           o_frame_start
);

    logic          rd_strip;
    logic [MW-1:0] mcu;
    logic [1:0]    blk;
    logic [2:0]    r;
    logic [2:0]    c;
    logic          active;
    logic          last;
    logic          blk_first;

    // Read enable, end-of-strip detect and strip release.
    always_comb begin
        active    = full[rd_strip];
        blk_first = (r == 3'd0) && (c == 3'd0);
        last      = (c == 3'd7) && (r == 3'd7) && (blk == 2'd3)
                    && (mcu == MW'(NM - 1));
        clr_full  = 2'b00;
        if (active && last) begin
            clr_full[rd_strip] = 1'b1;
        end
    end

    // Plane read addresses for the current sample.
    always_comb begin
        y_raddr = YAW'(int'(rd_strip) * 8 * W + int'(r) * W
                       + int'(mcu) * MCU_WIDTH + int'(blk[0]) * BLK_DIM + int'(c));
        c_raddr = CAW'(int'(rd_strip) * 4 * W + int'(r) * (W / 2)
                       + int'(mcu) * BLK_DIM + int'(c));
    end

    // Scan counters: column, row, block, MCU, then strip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_strip <= 1'b0;
            mcu      <= '0;
            blk      <= '0;
            r        <= '0;
            c        <= '0;
        end else if (active) begin
            c <= c + 3'd1;
            if (c == 3'd7) begin
                r <= r + 3'd1;
                if (r == 3'd7) begin
                    blk <= blk + 2'd1;
                    if (blk == 2'd3) begin
                        if (mcu == MW'(NM - 1)) begin
                            mcu      <= '0;
                            rd_strip <= ~rd_strip;
                        end else begin
                            mcu <= mcu + 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Output qualifiers, delayed to match the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid       <= 1'b0;
            o_tag         <= TAG_Y_LEFT;
            o_block_start <= 1'b0;
            o_frame_start <= 1'b0;
        end else begin
            o_valid       <= active;
            o_tag         <= blk_tag_e'(blk);
            o_block_start <= active && blk_first;
            o_frame_start <= active && blk_first && first_strip[rd_strip]
                             && (blk == 2'd0) && (mcu == '0);
        end
    end

endmodule

// File: rtl/yuyv_mcu_reorder.sv
// Top level: raster 4:2:2 input to 8x8 blocks in MCU order. Holds one
// luma and two chroma plane memories, each two strips deep, between the
// writer and the reader. Output has no backpressure.
module yuyv_mcu_reorder
    import mcu_reorder_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 16,
    localparam int YDEPTH = 2 * 8 * IMG_W,
    localparam int CDEPTH = 2 * 8 * (IMG_W / 2),
    localparam int YAW    = $clog2(YDEPTH),
    localparam int CAW    = $clog2(CDEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic        s_tlast,
    input  logic        s_tuser,
    output logic [7:0]  m_sample,
    output logic        m_valid,
    output logic [1:0]  m_tag,
    output logic        m_block_start,
    output logic        m_frame_start,
    output logic        line_err
);

    logic [1:0]     strip_full;
    logic [1:0]     first_strip;
    logic [1:0]     clr_full;
    logic           y_we;
    logic [YAW-1:0] y_waddr;
    logic [7:0]     y_wdata;
    logic           c_we [2];
    logic [CAW-1:0] c_waddr;
    logic [7:0]     c_wdata;
    logic [YAW-1:0] y_raddr;
    logic [CAW-1:0] c_raddr;
    logic [7:0]     y_rdata;
    logic [7:0]     c_rdata [2];
    blk_tag_e       tag_q;

    strip_writer #(.W(IMG_W), .H(IMG_H)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdata       (s_tdata),
        .tvalid      (s_tvalid),
        .tready      (s_tready),
        .tlast       (s_tlast),
        .tuser       (s_tuser),
        .clr_full    (clr_full),
        .full        (strip_full),
        .first_strip (first_strip),
        .y_we        (y_we),
        .y_waddr     (y_waddr),
        .y_wdata     (y_wdata),
        .cb_we       (c_we[0]),
        .cr_we       (c_we[1]),
        .c_waddr     (c_waddr),
        .c_wdata     (c_wdata),
        .line_err    (line_err)
    );

    lane_ram #(.DW(8), .DEPTH(YDEPTH)) u_luma_ram (
        .clk   (clk),
        .we    (y_we),
        .waddr (y_waddr),
        .wdata (y_wdata),
        .raddr (y_raddr),
        .rdata (y_rdata)
    );

    // One chroma plane memory per chroma component.
    for (genvar k = 0; k < 2; k++) begin : g_chroma
        lane_ram #(.DW(8), .DEPTH(CDEPTH)) u_chroma_ram (
            .clk   (clk),
            .we    (c_we[k]),
            .waddr (c_waddr),
            .wdata (c_wdata),
            .raddr (c_raddr),
            .rdata (c_rdata[k])
        );
    end

    mcu_reader #(.W(IMG_W)) u_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .full          (strip_full),
        .first_strip   (first_strip),
        .clr_full      (clr_full),
        .y_raddr       (y_raddr),
        .c_raddr       (c_raddr),
        .o_valid       (m_valid),
        .o_tag         (tag_q),
        .o_block_start (m_block_start),
        .o_frame_start (m_frame_start)
    );

    // Select the plane that matches the tag of the sample being emitted.
    always_comb begin
        m_tag = tag_q;
        unique case (tag_q)
            TAG_CB:  m_sample = c_rdata[0];
            TAG_CR:  m_sample = c_rdata[1];
            default: m_sample = y_rdata;
        endcase
    end

endmodule

// File: rtl/yuyv_mcu_reorder_chk.sv
// Protocol checker for the reorderer, bound to the top module.
module yuyv_mcu_reorder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_tready,
    input logic [1:0] strip_full,
    input logic       m_valid,
    input logic [1:0] m_tag,
    input logic       m_block_start,
    input logic       m_frame_start,
    input logic       line_err
);

    logic [5:0] smp_cnt;
    logic [1:0] prev_tag;
    logic       seen_blk;

    // Samples seen inside the current block, and the tag of the last block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cnt  <= '0;
            prev_tag <= '0;
            seen_blk <= 1'b0;
        end else if (m_valid) begin
            smp_cnt <= smp_cnt + 6'd1;
            if (m_block_start) begin
                prev_tag <= m_tag;
                seen_blk <= 1'b1;
            end
        end
    end

    // R5: a stall means both strips are occupied.
    p_stall_only_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_tready |-> (strip_full == 2'b11));

    // R2: a block start falls on a 64-sample boundary.
    p_block_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_block_start) |-> (smp_cnt == 6'd0));

    // R2: no gap inside a block.
    p_block_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && smp_cnt != 6'd63) |=> m_valid);

    // R2: tags advance 0,1,2,3 and wrap.
    p_tag_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_block_start && seen_blk) |-> (m_tag == prev_tag + 2'd1));

    // R4: markers only on valid samples; a frame start is a left-luma block start.
    p_marker_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_block_start || m_frame_start) |-> m_valid);
    p_frame_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_frame_start |-> (m_block_start && m_tag == 2'd0));

    // R7: the error flag is sticky.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> line_err);

endmodule

bind yuyv_mcu_reorder yuyv_mcu_reorder_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_tready      (s_tready),
    .strip_full    (strip_full),
    .m_valid       (m_valid),
    .m_tag         (m_tag),
    .m_block_start (m_block_start),
    .m_frame_start (m_frame_start),
    .line_err      (line_err)
);

// File: tb/test_yuyv_mcu_reorder.sv
// One bench lane: drives frames into a reorderer of a given size and
// scores every output sample against values computed from coordinates.
module reorder_lane #(
    parameter int W      = 32,
    parameter int H      = 16,
    parameter int NFR    = 2,
    parameter bit JUNK   = 0,
    parameter bit SHORTS = 0
) (
    input  logic clk,
    input  logic rst_n,
    output int   errs,
    output int   checks,
    output logic done
);
    localparam int NS = H / 8;
    localparam int NM = W / 16;
    localparam int SAMPLES = NFR * NS * NM * 256;

    logic [15:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        s_tlast = 1'b0;
    logic        s_tuser = 1'b0;
    logic [7:0]  m_sample;
    logic        m_valid;
    logic [1:0]  m_tag;
    logic        m_block_start;
    logic        m_frame_start;
    logic        line_err;

    yuyv_mcu_reorder #(.IMG_W(W), .IMG_H(H)) i_yuyv_mcu_reorder (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_sample(m_sample), .m_valid(m_valid), .m_tag(m_tag),
        .m_block_start(m_block_start), .m_frame_start(m_frame_start),
        .line_err(line_err)
    );

    function automatic logic [7:0] luma(int f, int x, int y);
        return 8'((x * 3 + y * 7 + f * 11) & 255);
    endfunction
    function automatic logic [7:0] cbv(int f, int p, int y);
        return 8'((p * 5 + y * 13 + f + 64) & 255);
    endfunction
    function automatic logic [7:0] crv(int f, int p, int y);
        return 8'((p * 9 + y * 3 + f * 7 + 128) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s W=%0d: actual=%0d expected=%0d", req, W, act, exp);
        end
    endtask

    int  lines_acc = 0;
    bit  saw_stall = 0;
    bit  scoring = 1;
    int  scored = 0;
    int  extra_valid = 0;

    // Send one beat with a random idle gap; returns after acceptance.
    task automatic send(input logic [15:0] d, input bit u, input bit l);
        int gap;
        gap = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
        repeat (gap) begin
            @(negedge clk);
            s_tvalid = 1'b0;
        end
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tuser = u; s_tlast = l;
        while (!s_tready) begin
            saw_stall = 1;
            @(negedge clk);
        end
        @(posedge clk);
        if (l) lines_acc++;
    endtask

    task automatic send_frame(input int f);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                logic [7:0] cv;
                cv = x[0] ? crv(f, x / 2, y) : cbv(f, x / 2, y);
                send({cv, luma(f, x, y)}, (x == 0 && y == 0), (x == W - 1));
            end
        end
    endtask

    // Scoreboard position: frame, strip, MCU, block, row, column.
    int sf = 0, ss = 0, sm = 0, sb = 0, sr = 0, sc = 0;

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            if (!scoring) begin
                extra_valid++;
            end else if (scored < SAMPLES) begin
                int yy, xx, pp, ex;
                yy = ss * 8 + sr;
                pp = sm * 8 + sc;
                xx = sm * 16 + (sb == 1 ? 8 : 0) + sc;
                ex = (sb < 2) ? int'(luma(sf, xx, yy)) :
                     (sb == 2) ? int'(cbv(sf, pp, yy)) : int'(crv(sf, pp, yy));
                chk(m_sample == 8'(ex), "R1 R2 R6 R8 sample", m_sample, ex);
                chk(m_tag == 2'(sb), "R2 tag", m_tag, sb);
                chk(m_block_start == (sr == 0 && sc == 0), "R4 block_start",
                    m_block_start, (sr == 0 && sc == 0));
                chk(m_frame_start == (ss == 0 && sm == 0 && sb == 0 && sr == 0 && sc == 0),
                    "R4 frame_start", m_frame_start, (ss == 0 && sm == 0 && sb == 0));
                if (sm == 0 && sb == 0 && sr == 0 && sc == 0)
                    chk(lines_acc >= (sf * NS + ss + 1) * 8, "R3 strip complete before output",
                        lines_acc, (sf * NS + ss + 1) * 8);
                scored++;
                sc++;
                if (sc == 8) begin sc = 0; sr++; end
                if (sr == 8) begin sr = 0; sb++; end
                if (sb == 4) begin sb = 0; sm++; end
                if (sm == NM) begin sm = 0; ss++; end
                if (ss == NS) begin ss = 0; sf++; end
            end
        end
    end

    initial begin
        errs = 0; checks = 0; done = 1'b0;
        @(posedge rst_n);
        @(negedge clk);
        chk(s_tready == 1'b1, "R9 tready after reset", s_tready, 1);
        chk(m_valid == 1'b0, "R9 valid after reset", m_valid, 0);
        chk(line_err == 1'b0, "R9 line_err after reset", line_err, 0);
        for (int f = 0; f < NFR; f++) begin
            if (JUNK && f == 1) begin
                // Partial junk line: tuser of the next frame must discard it (R6).
                for (int k = 0; k < 10; k++) send(16'hA5A5, 1'b0, 1'b0);
            end
            send_frame(f);
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = 1'b0;
        while (scored < SAMPLES) @(negedge clk);
        chk(scored == SAMPLES, "R8 R3 all samples emitted", scored, SAMPLES);
        chk(saw_stall == 1'b1, "R5 backpressure seen", saw_stall, 1);
        chk(line_err == 1'b0, "R7 no error on full lines", line_err, 0);
        if (SHORTS) begin
            scoring = 0;
            for (int y = 0; y < 8; y++)
                for (int x = 0; x < 5; x++)
                    send(16'h1234, (x == 0 && y == 0), (x == 4));
            @(negedge clk);
            s_tvalid = 1'b0; s_tlast = 1'b0; s_tuser = 1'b0;
            chk(line_err == 1'b1, "R7 early tlast sets line_err", line_err, 1);
            repeat (NS * NM * 256 + 20) @(negedge clk);
            chk(extra_valid == NM * 256, "R7 short lines complete a strip",
                extra_valid, NM * 256);
            chk(line_err == 1'b1, "R7 line_err sticky", line_err, 1);
        end
        done = 1'b1;
    end
endmodule

// Bench top: two sizes of the reorderer, shared clock and reset.
module test_yuyv_mcu_reorder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   e_a, c_a, e_b, c_b;
    logic d_a, d_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reorder_lane #(.W(32), .H(16), .NFR(2), .JUNK(1), .SHORTS(0)) u_wide (
        .clk(clk), .rst_n(rst_n), .errs(e_a), .checks(c_a), .done(d_a));
    reorder_lane #(.W(16), .H(8), .NFR(3), .JUNK(0), .SHORTS(1)) u_min (
        .clk(clk), .rst_n(rst_n), .errs(e_b), .checks(c_b), .done(d_b));

    initial begin
        int cyc;
        int wd_err;
        wd_err = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!(d_a && d_b) && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d_a && d_b)) begin
            wd_err = 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
        end
        $display("Result: errors=%0d of %0d checks", e_a + e_b + wd_err, c_a + c_b + wd_err);
        $finish;
    end
endmodule